// File: doc/BRIEF.md
# Programmable-Length Row Scan Ring Counter

This block drives the common (row) electrodes of a passive matrix display. It produces a single active-high scan pulse that walks across a bank of row outputs, one row per rising edge of the row clock. The number of rows taking part in the scan is chosen at run time by a binary count input, so one instance can serve panels of different heights. Rows at or above the count are held low.

The scan walks downward, from the highest row in the range to row 0, and then wraps back to the top of the range. The count is sampled on every row clock edge. A new nonzero value makes the pulse jump to the top row of the new range on that same edge, and the scan continues from there. A count of zero stops the scan and leaves every row low.

Top module: `rowScanRing`

## Requirements
- R1: While `rst` is high, every bit of `comOut` is low after each clock edge.
- R2: At most one bit of `comOut` is high at any time.
- R3: The first edge after reset, or after an idle period, that samples a nonzero count N drives only row N-1 high.
- R4: If an edge samples the same count as the previous edge and the active row k is above 0, the active row becomes k-1.
- R5: If an edge samples the same count N as the previous edge and row 0 is active, the active row wraps to N-1.
- R6: For a sampled count N, rows N through 63 stay low.
- R7: An edge that samples a count of 0 drives all rows low.
- R8: An edge that samples a nonzero count different from the previous sampled count drives only row (new count - 1) high, whatever row was active before.
- R9: With a count of 1, row 0 stays high on every edge and every other row stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Row clock. The scan advances on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. |
| rowCount | input | 6 | Number of rows in the scan, 0 to 63. |
| comOut | output | 64 | One-hot row drive. Bit i drives row i. |

## Verification
The hardest case to reach is a count change that lands while the pulse sits at an arbitrary point inside the old range, including at row 0 in the same cycle a wrap would occur. The count also has to be released from zero back into a scan. The bench steps through every count from 1 to 63 for more than two full laps each. Each step to the next count switches the value while the previous scan is at a different position. Directed runs then switch between counts partway through a lap, park the count at zero, and assert reset in the middle of a scan.

// File: rtl/rowScanPkg.sv
`timescale 1ns/1ps
package rowScanPkg;
  // Exactly one strobe is raised by the control on every cycle.
  typedef struct packed {
    logic clear;  // stop scanning, all rows low
    logic load;   // place the pulse on the top row of the range
    logic step;   // move the pulse down by one row
  } scanStrb_t;
endpackage

// File: rtl/rowScanCtrl.sv
`timescale 1ns/1ps
module rowScanCtrl
  import rowScanPkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rowCount,
  input  logic             running,
  input  logic             atBottom,
  output scanStrb_t        strb
);

  logic [CNT_W-1:0] lastCount;

  always_ff @(posedge clk) begin
    if (rst) lastCount <= '0;
    else     lastCount <= rowCount;
  end

  always_comb begin
    strb = '0;
    if (rowCount == '0)
      strb.clear = 1'b1;
    else if ((rowCount != lastCount) || !running || atBottom)
      strb.load = 1'b1;
    else
      strb.step = 1'b1;
  end

  // R2: the control never issues two actions at once, and never issues none.
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot({strb.clear, strb.load, strb.step}));

  // R8: a changed nonzero count never lets the pulse simply step on.
  a_r8_change_no_step: assert property (@(posedge clk) disable iff (rst)
    (rowCount != lastCount) |-> !strb.step);

endmodule

// File: rtl/rowScanPath.sv
`timescale 1ns/1ps
module rowScanPath
  import rowScanPkg::*;
#(
  parameter int NUM_ROWS = 64,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    rowCount,
  input  scanStrb_t           strb,
  output logic                running,
  output logic                atBottom,
  output logic [NUM_ROWS-1:0] comOut
);

  logic [CNT_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      ptr     <= '0;
    end else if (strb.clear) begin
      running <= 1'b0;
    end else if (strb.load) begin
      running <= 1'b1;
      ptr     <= rowCount - 1'b1;
    end else if (strb.step) begin
      ptr     <= ptr - 1'b1;
    end
  end

  assign atBottom = (ptr == '0);

  for (genvar g = 0; g < NUM_ROWS; g++) begin : gRow
    assign comOut[g] = running && (ptr == CNT_W'(g));
  end

  // R4: a step moves the pointer down by exactly one row.
  a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
    strb.step |=> (running && ptr == $past(ptr) - 1'b1));

  // R3/R5/R8: a load always lands on the top row of the sampled range.
  a_r5_load_top: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (running && ptr == $past(rowCount) - 1'b1));

  // R7: a clear leaves the scan idle.
  a_r7_clear_idle: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=> !running);

endmodule

// File: rtl/rowScanRing.sv
`timescale 1ns/1ps
module rowScanRing
  import rowScanPkg::*;
#(
  parameter  int NUM_ROWS = 64,
  localparam int CNT_W    = $clog2(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    rowCount,
  output logic [NUM_ROWS-1:0] comOut
);

  scanStrb_t strb;
  logic      running;
  logic      atBottom;

  rowScanCtrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rowCount (rowCount),
    .running  (running),
    .atBottom (atBottom),
    .strb     (strb)
  );

  rowScanPath #(.NUM_ROWS(NUM_ROWS), .CNT_W(CNT_W)) i_path (
    .clk      (clk),
    .rst      (rst),
    .rowCount (rowCount),
    .strb     (strb),
    .running  (running),
    .atBottom (atBottom),
    .comOut   (comOut)
  );

  // R2: never more than one row driven.
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(comOut));

  // R7: a zero count leaves every row low after the edge.
  a_r7_zero_dark: assert property (@(posedge clk) disable iff (rst)
    (rowCount == '0) |=> (comOut == '0));

endmodule

// File: tb/test_rowScanRing.sv
`timescale 1ns/1ps
module test_rowScanRing;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  rowCount = '0;
  logic [63:0] comOut;

  int nChk = 0;
  int nFail = 0;
  int expIdx = -1;   // active row expected, -1 for none
  int lastN = 0;     // count sampled at the previous edge

  always #10 clk = ~clk;

  rowScanRing i_rowScanRing (
    .clk      (clk),
    .rst      (rst),
    .rowCount (rowCount),
    .comOut   (comOut)
  );

  function automatic logic [63:0] expVec();
    return (expIdx < 0) ? 64'd0 : (64'd1 << expIdx);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1;
      check("R1 reset", comOut, 64'd0);
    end
    rst = 1'b0;
    expIdx = -1;
    lastN = 0;
  endtask

  task automatic edgeStep(int n);
    string tag;
    rowCount = 6'(n);
    @(posedge clk); #1;
    if (n == 0) begin
      expIdx = -1; tag = "R7 zero count";
    end else if (expIdx < 0 && n == lastN) begin
      expIdx = n - 1; tag = "R3 start";
    end else if (n != lastN) begin
      expIdx = n - 1; tag = (lastN == 0) ? "R3 start" : "R8 count change";
    end else if (n == 1) begin
      expIdx = 0; tag = "R9 single row";
    end else if (expIdx == 0) begin
      expIdx = n - 1; tag = "R5 wrap";
    end else begin
      expIdx = expIdx - 1; tag = "R4 step";
    end
    lastN = n;
    check(tag, comOut, expVec());
    check("R2 one hot", 64'($countones(comOut) <= 1), 64'd1);
    if (n > 0) check("R6 out of range low", comOut >> n, 64'd0);
  endtask

  task automatic run(int n, int cycles);
    for (int i = 0; i < cycles; i++) edgeStep(n);
  endtask

  initial begin
    #1;
    doReset();
    // Sweep every count through more than two laps.
    for (int n = 1; n < 64; n++) run(n, 2 * n + 3);
    // Directed: change partway through a lap.
    doReset();
    run(27, 10);
    run(35, 40);
    run(0, 3);
    run(5, 12);
    // Reset in the middle of a scan, then restart.
    doReset();
    run(1, 4);
    run(62, 7);
    run(34, 36);
    // Change exactly when row 0 is active.
    run(3, 3);
    run(9, 4);
    run(0, 1);
    run(9, 10);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule